// File: doc/BRIEF.md
# IOTLB Flush Controller

This block sits behind the register write path of an address-remapping unit. Software writes a 64-bit flush-command register and a 64-bit flush-address register. When a write to the command register sets its trigger bit, the block decodes the requested scope in the next cycle. The scope is one of three: every cached translation, every translation of one domain, or an aligned range of pages within one domain. The block then sends one command strobe, with its fields, to the translation cache.

In the same cycle the block clears the trigger bit and writes the granularity it actually carried out into the command register, so software can poll for completion. A zero granularity code means the request was refused. That happens for a requested scope of 0, and for a page request whose mask order is above the advertised limit. A constant capability word tells software that page-scoped flushes are supported and gives the largest mask order.

Top module: `iotlb_flush_ctrl`

## Requirements
- R1: After a synchronous active-high reset, the command register, the address register and all command outputs are zero, and `cmd_valid` is low.
- R2: `cap_reg_q` is constant: bit 39 is 1, bits 53:48 hold `MAX_ORDER` (9 by default), and every other bit is 0.
- R3: The command register (`wr_sel` = 0) is loaded with all 64 bits of `wr_data` only by a 64-bit write (`wr_wide` = 1). A 32-bit write to it is ignored. Any write to it is also ignored while its bit 63 is 1.
- R4: Writes to the address register follow `wr_sel` and `wr_wide`. With `wr_sel` = 1 and `wr_wide` = 1, all 64 bits are written. With `wr_sel` = 1 and `wr_wide` = 0, only bits 31:0 are written. With `wr_sel` = 2 and `wr_wide` = 0, bits 63:32 are loaded from `wr_data[31:0]`. With `wr_sel` = 2 and `wr_wide` = 1, the write is ignored. `wr_sel` = 3 writes nothing.
- R5: Bit 63 of the command register is the trigger. One clock edge after bit 63 becomes 1, the block does three things at once: it clears bit 63, it writes the actual granularity code into bits 58:57, and it drives `cmd_valid` high for exactly one cycle if the request was accepted. A command write with bit 63 at 0 only stores the value.
- R6: A requested granularity of 1 in bits 61:60 gives `cmd_kind` = 1 with domain, address and order all zero, and reports actual granularity 1.
- R7: A requested granularity of 2 gives `cmd_kind` = 2 with `cmd_domain` taken from command bits 47:32, and reports actual granularity 2.
- R8: A requested granularity of 3 with mask order ≤ `MAX_ORDER` gives `cmd_kind` = 3. `cmd_domain` comes from command bits 47:32. `cmd_addr` is address-register bits 38:12 followed by 12 zero bits. `cmd_order` is address-register bits 5:0. The reported actual granularity is 3. An order equal to `MAX_ORDER` is accepted.
- R9: A requested granularity of 3 with mask order > `MAX_ORDER` issues no strobe and reports actual granularity 0.
- R10: A requested granularity of 0 issues no strobe and reports actual granularity 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 command, 1 address low/full, 2 address high, 3 none |
| wr_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| wr_data | input | 64 | Write data |
| cmd_valid | output | 1 | One-cycle invalidation strobe |
| cmd_kind | output | 2 | 1 global, 2 domain, 3 page range |
| cmd_domain | output | DOM_W | Domain identifier |
| cmd_addr | output | GAW | Page-aligned base address |
| cmd_order | output | ORD_W | Address mask order (log2 of page count) |
| inv_reg_q | output | 64 | Command register contents |
| iva_reg_q | output | 64 | Address register contents |
| cap_reg_q | output | 64 | Capability word |

## Verification
Register writes show up at the outputs one edge after the write cycle. The strobe, its fields, the cleared trigger and the reported granularity all appear one edge after that, which is two edges after the triggering write. The bench drives inputs on falling edges. It updates a behavioural model on each rising edge and compares every output against that model at each falling edge, so every result is compared in exactly the cycle it becomes due. The directed checks wait the same two edges after a trigger before sampling. They also cover a command write made in the completion cycle itself, which must be dropped.

// File: rtl/iotlb_flush_pkg.sv
package iotlb_flush_pkg;

    // Fixed register geometry
    localparam int REG_W       = 64;
    localparam int HALF_W      = 32;
    localparam int PG_SHIFT    = 12;
    localparam int TRIG_BIT    = 63;
    localparam int REQ_LSB     = 60;
    localparam int ACT_LSB     = 57;
    localparam int DOM_LSB     = 32;
    localparam int CAP_PSI_BIT = 39;
    localparam int CAP_ORD_LSB = 48;
    localparam int CAP_ORD_W   = 6;

    typedef enum logic [1:0] {
        GR_NONE   = 2'd0,
        GR_GLOBAL = 2'd1,
        GR_DOMAIN = 2'd2,
        GR_PAGE   = 2'd3
    } gran_e;

    typedef enum logic [1:0] {
        SEL_CMD     = 2'd0,
        SEL_ADDR_LO = 2'd1,
        SEL_ADDR_HI = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

    function automatic logic [REG_W-1:0] cap_word(input int max_order);
        logic [REG_W-1:0] w;
        w = '0;
        w[CAP_PSI_BIT] = 1'b1;
        w[CAP_ORD_LSB +: CAP_ORD_W] = CAP_ORD_W'(max_order);
        return w;
    endfunction

endpackage

// File: rtl/flush_regs.sv
module flush_regs
    import iotlb_flush_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic             wr_wide,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       act_gran,
    output logic [REG_W-1:0] cmd_q,
    output logic [REG_W-1:0] addr_q
);
    localparam int N_HALF = REG_W / HALF_W;

    reg_sel_e sel;
    logic     done;
    assign sel  = reg_sel_e'(wr_sel);
    assign done = cmd_q[TRIG_BIT];

    // Command register: completion has priority and blocks new writes
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (done) begin
            cmd_q[TRIG_BIT]        <= 1'b0;
            cmd_q[ACT_LSB +: 2]    <= act_gran;
        end else if (wr_en && sel == SEL_CMD && wr_wide) begin
            cmd_q <= wr_data;
        end
    end

    // Address register, one write port per 32-bit half
    logic [N_HALF-1:0]       half_we;
    logic [HALF_W-1:0]       half_wd [N_HALF];

    always_comb begin
        half_we[0] = wr_en && sel == SEL_ADDR_LO;
        half_wd[0] = wr_data[HALF_W-1:0];
        half_we[1] = wr_en && ((sel == SEL_ADDR_LO && wr_wide) ||
                               (sel == SEL_ADDR_HI && !wr_wide));
        half_wd[1] = (sel == SEL_ADDR_LO) ? wr_data[REG_W-1:HALF_W]
                                          : wr_data[HALF_W-1:0];
    end

    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        always_ff @(posedge clk) begin
            if (rst) begin
                addr_q[h*HALF_W +: HALF_W] <= '0;
            end else if (half_we[h]) begin
                addr_q[h*HALF_W +: HALF_W] <= half_wd[h];
            end
        end
    end

endmodule

// File: rtl/flush_decode.sv
module flush_decode
    import iotlb_flush_pkg::*;
#(
    parameter int DOM_W     = 16,
    parameter int GAW       = 39,
    parameter int ORD_W     = 6,
    parameter int MAX_ORDER = 9
) (
    input  logic [1:0]             req_gran,
    input  logic [DOM_W-1:0]       req_dom,
    input  logic [GAW-1:PG_SHIFT]  page_num,
    input  logic [ORD_W-1:0]       mask_ord,
    output gran_e                  act_gran,
    output logic [DOM_W-1:0]       out_dom,
    output logic [GAW-1:0]         out_addr,
    output logic [ORD_W-1:0]       out_ord
);
    localparam logic [ORD_W-1:0] ORD_LIMIT = ORD_W'(MAX_ORDER);

    always_comb begin
        act_gran = GR_NONE;
        out_dom  = '0;
        out_addr = '0;
        out_ord  = '0;
        case (gran_e'(req_gran))
            GR_GLOBAL: act_gran = GR_GLOBAL;
            GR_DOMAIN: begin
                act_gran = GR_DOMAIN;
                out_dom  = req_dom;
            end
            GR_PAGE: begin
                if (mask_ord <= ORD_LIMIT) begin
                    act_gran = GR_PAGE;
                    out_dom  = req_dom;
                    out_addr = {page_num, {PG_SHIFT{1'b0}}};
                    out_ord  = mask_ord;
                end
            end
            default: act_gran = GR_NONE;
        endcase
    end

endmodule

// File: rtl/iotlb_flush_ctrl.sv
module iotlb_flush_ctrl
    import iotlb_flush_pkg::*;
#(
    parameter int DOM_W     = 16,
    parameter int GAW       = 39,
    parameter int ORD_W     = 6,
    parameter int MAX_ORDER = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic             wr_wide,
    input  logic [63:0]      wr_data,
    output logic             cmd_valid,
    output logic [1:0]       cmd_kind,
    output logic [DOM_W-1:0] cmd_domain,
    output logic [GAW-1:0]   cmd_addr,
    output logic [ORD_W-1:0] cmd_order,
    output logic [63:0]      inv_reg_q,
    output logic [63:0]      iva_reg_q,
    output logic [63:0]      cap_reg_q
);
    gran_e              dec_act;
    logic [DOM_W-1:0]   dec_dom;
    logic [GAW-1:0]     dec_addr;
    logic [ORD_W-1:0]   dec_ord;
    logic               busy;

    assign busy      = inv_reg_q[TRIG_BIT];
    assign cap_reg_q = cap_word(MAX_ORDER);

    flush_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_wide  (wr_wide),
        .wr_data  (wr_data),
        .act_gran (dec_act),
        .cmd_q    (inv_reg_q),
        .addr_q   (iva_reg_q)
    );

    flush_decode #(
        .DOM_W     (DOM_W),
        .GAW       (GAW),
        .ORD_W     (ORD_W),
        .MAX_ORDER (MAX_ORDER)
    ) u_dec (
        .req_gran (inv_reg_q[REQ_LSB +: 2]),
        .req_dom  (inv_reg_q[DOM_LSB +: DOM_W]),
        .page_num (iva_reg_q[GAW-1:PG_SHIFT]),
        .mask_ord (iva_reg_q[ORD_W-1:0]),
        .act_gran (dec_act),
        .out_dom  (dec_dom),
        .out_addr (dec_addr),
        .out_ord  (dec_ord)
    );

    // Command strobe, issued on the same edge that completes the request
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid  <= 1'b0;
            cmd_kind   <= '0;
            cmd_domain <= '0;
            cmd_addr   <= '0;
            cmd_order  <= '0;
        end else begin
            cmd_valid <= busy && dec_act != GR_NONE;
            if (busy && dec_act != GR_NONE) begin
                cmd_kind   <= dec_act;
                cmd_domain <= dec_dom;
                cmd_addr   <= dec_addr;
                cmd_order  <= dec_ord;
            end
        end
    end

endmodule

// File: rtl/iotlb_flush_chk.sv
module iotlb_flush_chk #(
    parameter int DOM_W     = 16,
    parameter int GAW       = 39,
    parameter int ORD_W     = 6,
    parameter int MAX_ORDER = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic             wr_wide,
    input logic             cmd_valid,
    input logic [1:0]       cmd_kind,
    input logic [ORD_W-1:0] cmd_order,
    input logic [63:0]      inv_reg_q,
    input logic [63:0]      iva_reg_q
);
    // R5
    trig_clear_chk: assert property (@(posedge clk) disable iff (rst)
        inv_reg_q[63] |=> !inv_reg_q[63]);

    // R5
    strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(inv_reg_q[63]));

    // R5
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R5
    report_match_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (inv_reg_q[58:57] == cmd_kind && cmd_kind != 2'd0));

    // R9
    order_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == 2'd3) |-> cmd_order <= ORD_W'(MAX_ORDER));

    // R9 and R10: a refused request raises no strobe
    refuse_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(inv_reg_q[63]) && inv_reg_q[58:57] == 2'd0) |-> !cmd_valid);

    // R3
    narrow_cmd_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd0 && !wr_wide && !inv_reg_q[63]) |=> $stable(inv_reg_q));

    // R4
    wide_high_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd2 && wr_wide) |=> $stable(iva_reg_q));

endmodule

bind iotlb_flush_ctrl iotlb_flush_chk #(
    .DOM_W     (DOM_W),
    .GAW       (GAW),
    .ORD_W     (ORD_W),
    .MAX_ORDER (MAX_ORDER)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_wide   (wr_wide),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .cmd_order (cmd_order),
    .inv_reg_q (inv_reg_q),
    .iva_reg_q (iva_reg_q)
);

// File: tb/sim_iotlb_flush_ctrl.sv
`timescale 1ns/1ps
module sim_iotlb_flush_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic        wr_wide = 1'b0;
    logic [63:0] wr_data = '0;
    logic        cmd_valid;
    logic [1:0]  cmd_kind;
    logic [15:0] cmd_domain;
    logic [38:0] cmd_addr;
    logic [5:0]  cmd_order;
    logic [63:0] inv_reg_q, iva_reg_q, cap_reg_q;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    iotlb_flush_ctrl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_wide(wr_wide),
        .wr_data(wr_data), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_domain(cmd_domain), .cmd_addr(cmd_addr), .cmd_order(cmd_order),
        .inv_reg_q(inv_reg_q), .iva_reg_q(iva_reg_q), .cap_reg_q(cap_reg_q)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [63:0] m_inv, m_iva;
    logic        m_valid;
    logic [1:0]  m_kind;
    logic [15:0] m_dom;
    logic [38:0] m_addr;
    logic [5:0]  m_ord;

    always @(posedge clk) begin
        if (rst) begin
            m_inv = '0; m_iva = '0; m_valid = 0;
            m_kind = '0; m_dom = '0; m_addr = '0; m_ord = '0;
        end else begin
            int g, o, a;
            logic busy;
            busy = m_inv[63];
            m_valid = 0;
            if (busy) begin
                g = int'(m_inv[61:60]);
                o = int'(m_iva[5:0]);
                if (g == 0) a = 0;
                else if (g == 3 && o > 9) a = 0;
                else a = g;
                if (a != 0) begin
                    m_valid = 1;
                    m_kind  = 2'(a);
                    m_dom   = (a == 1) ? 16'h0 : m_inv[47:32];
                    m_addr  = (a == 3) ? {m_iva[38:12], 12'h000} : 39'h0;
                    m_ord   = (a == 3) ? m_iva[5:0] : 6'h0;
                end
                m_inv[63] = 0;
                m_inv[58:57] = 2'(a);
            end
            if (wr_en) begin
                if (wr_sel == 2'd0 && wr_wide && !busy) m_inv = wr_data;
                else if (wr_sel == 2'd1 && wr_wide) m_iva = wr_data;
                else if (wr_sel == 2'd1) m_iva[31:0] = wr_data[31:0];
                else if (wr_sel == 2'd2 && !wr_wide) m_iva[63:32] = wr_data[31:0];
            end
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R3 command register vs model", inv_reg_q, m_inv);
            chk("R4 address register vs model", iva_reg_q, m_iva);
            chk("R5 strobe vs model", 64'(cmd_valid), 64'(m_valid));
            if (m_valid) begin
                chk("R6 R7 R8 kind vs model", 64'(cmd_kind), 64'(m_kind));
                chk("R7 R8 domain vs model", 64'(cmd_domain), 64'(m_dom));
                chk("R8 address vs model", 64'(cmd_addr), 64'(m_addr));
                chk("R8 order vs model", 64'(cmd_order), 64'(m_ord));
            end
        end
    end

    task automatic wr(input logic [1:0] sel, input logic wide, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_wide = wide; wr_data = d;
        @(negedge clk);
        wr_en = 0; wr_sel = 2'd3; wr_wide = 0; wr_data = '0;
    endtask

    // Trigger a flush and sample after the completion edge
    task automatic fire(input logic [63:0] d);
        wr(2'd0, 1'b1, d);
        @(negedge clk);
    endtask

    task automatic expect_cmd(input string tag, input logic v, input logic [1:0] k,
                              input logic [15:0] dm, input logic [38:0] ad,
                              input logic [5:0] od, input logic [1:0] act);
        chk({tag, " strobe"}, 64'(cmd_valid), 64'(v));
        chk({tag, " trigger cleared and granularity"},
            64'({inv_reg_q[63], inv_reg_q[58:57]}), 64'({1'b0, act}));
        if (v) begin
            chk({tag, " kind"}, 64'(cmd_kind), 64'(k));
            chk({tag, " domain"}, 64'(cmd_domain), 64'(dm));
            chk({tag, " address"}, 64'(cmd_addr), 64'(ad));
            chk({tag, " order"}, 64'(cmd_order), 64'(od));
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        chk("R1 command register reset", inv_reg_q, 64'h0);
        chk("R1 address register reset", iva_reg_q, 64'h0);
        chk("R1 strobe reset", 64'(cmd_valid), 64'h0);
        chk("R1 fields reset", 64'({cmd_kind, cmd_domain, cmd_order}), 64'h0);
        // R2
        chk("R2 capability word", cap_reg_q, (64'h1 << 39) | (64'd9 << 48));

        // R4 split writes
        wr(2'd1, 1'b0, 64'hDEAD_BEEF_1234_5678);
        chk("R4 low half only", iva_reg_q, 64'h0000_0000_1234_5678);
        wr(2'd2, 1'b0, 64'hCAFE_CAFE_0000_0012);
        chk("R4 high half from low data", iva_reg_q, 64'h0000_0012_1234_5678);
        wr(2'd2, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R4 wide write to high half ignored", iva_reg_q, 64'h0000_0012_1234_5678);
        wr(2'd3, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R4 unused select ignored", iva_reg_q, 64'h0000_0012_1234_5678);
        wr(2'd1, 1'b1, 64'hFFFF_FF9A_BCDE_F247);
        chk("R4 full wide write", iva_reg_q, 64'hFFFF_FF9A_BCDE_F247);

        // R3 narrow write and untriggered write
        wr(2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R3 narrow command write ignored", inv_reg_q, 64'h0);
        wr(2'd0, 1'b1, 64'h2000_0042_0000_0000);
        chk("R3 untriggered value stored", inv_reg_q, 64'h2000_0042_0000_0000);
        @(negedge clk);
        chk("R5 no strobe without trigger", 64'(cmd_valid), 64'h0);

        // R7 domain
        fire(64'hA000_BEEF_0000_0000);
        expect_cmd("R7 domain flush", 1, 2'd2, 16'hBEEF, 39'h0, 6'h0, 2'd2);
        @(negedge clk);
        chk("R5 strobe lasts one cycle", 64'(cmd_valid), 64'h0);

        // R6 global
        fire(64'h9000_7777_0000_0000);
        expect_cmd("R6 global flush", 1, 2'd1, 16'h0, 39'h0, 6'h0, 2'd1);

        // R8 page, order 7
        fire(64'hB000_1234_0000_0000);
        expect_cmd("R8 page flush", 1, 2'd3, 16'h1234, 39'h1A_BCDE_F000, 6'd7, 2'd3);

        // R8 boundary order 9
        wr(2'd1, 1'b1, 64'h0000_0000_0040_1009);
        fire(64'hB000_0005_0000_0000);
        expect_cmd("R8 page flush at order limit", 1, 2'd3, 16'h0005, 39'h40_1000, 6'd9, 2'd3);

        // R9 order 10 and 63
        wr(2'd1, 1'b1, 64'h0000_0000_0040_100A);
        fire(64'hB000_0005_0000_0000);
        expect_cmd("R9 order 10 refused", 0, 2'd0, 16'h0, 39'h0, 6'h0, 2'd0);
        wr(2'd1, 1'b0, 64'h0000_0000_0000_003F);
        fire(64'hB000_0006_0000_0000);
        expect_cmd("R9 order 63 refused", 0, 2'd0, 16'h0, 39'h0, 6'h0, 2'd0);

        // R10 invalid granularity
        fire(64'h8000_5555_0000_0000);
        expect_cmd("R10 granularity 0 refused", 0, 2'd0, 16'h0, 39'h0, 6'h0, 2'd0);

        // R3 write during completion cycle is dropped
        @(negedge clk);
        wr_en = 1; wr_sel = 2'd0; wr_wide = 1; wr_data = 64'hA000_0101_0000_0000;
        @(negedge clk);
        wr_data = 64'h9000_0000_0000_0000;
        @(negedge clk);
        wr_en = 0; wr_sel = 2'd3; wr_wide = 0; wr_data = '0;
        expect_cmd("R3 first request completes", 1, 2'd2, 16'h0101, 39'h0, 6'h0, 2'd2);
        chk("R3 busy-cycle write dropped", 64'(inv_reg_q[61:60]), 64'd2);
        @(negedge clk);
        chk("R3 no second strobe", 64'(cmd_valid), 64'h0);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule